// File: doc/BRIEF.md
# Real-Time Clock with Shadowed Readout

This block is a memory-mapped real-time clock. It takes a slow time-base enable, nominally 32 kHz, and turns it into millisecond ticks with a fractional accumulator, so the average tick rate is exact. The ticks drive a milliseconds counter and a seconds counter. Software reads time from a bus-side copy of those counters. A new copy is taken once for every eight time-base enables. While the copy is in progress, a busy flag is high and every register write is dropped.

Reading the milliseconds register captures the bus-side seconds into a shadow register. A later read of the shadow register therefore gives the seconds that belong to the milliseconds value just read. Two seconds alarms and one milliseconds alarm compare against the live counters. Each alarm sets a sticky status bit, and each status bit has a mask bit. Status bits are cleared by writing 1 to them. The interrupt output is an active-high level.

Top module: `rtc_shadowed`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads 0 and `irq` is 0.
- R2: After N time-base enables since reset, the millisecond count is floor(N·TICK_HZ/TB_HZ) modulo 1000, with the remainder carried by an accumulator. That count is visible at offset 0x010 once the copy that follows has finished.
- R3: The milliseconds counter wraps from 999 to 0, and seconds (offset 0x008) increments on the same tick.
- R4: Offset 0x004 bit 0 reads 1 for COPY_CYCLES clocks after every eighth time-base enable and reads 0 at all other times. The bus-side time registers update at the end of that window.
- R5: Any write that arrives while busy is 1 is ignored.
- R6: A read of 0x010 loads the bus-side seconds into the shadow register at 0x00c. The shadow keeps that value until the next such read.
- R7: Writing 0x008 while not busy sets seconds to the written value and clears milliseconds to 0.
- R8: Seconds alarm 0 is at 0x014 and seconds alarm 1 is at 0x018. Each sets its status bit (bit 0 and bit 1 respectively) on the tick in which seconds becomes equal to its nonzero value, whatever the mask says.
- R9: The milliseconds alarm is at 0x01c. It sets status bit 2 on the tick in which milliseconds becomes equal to its nonzero value.
- R10: An alarm register that holds 0 never sets its status bit.
- R11: Status (0x02c) is write-1-to-clear. Bits written as 0 keep their value, and writing 0xFFFFFFFF clears every bit.
- R12: `irq` is 1 exactly while some status bit and the mask bit (0x028) at the same position are both 1.
- R13: The mask keeps only bits 4:0. Status bits 3 and 4 (the countdown events) always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tb_en | input | 1 | One-cycle time-base enable (32 kHz nominal) |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after `rd_en` |
| irq | output | 1 | Active-high level interrupt |

## Verification
The hardest situation to reach is a write that lands inside the busy window. That window opens only on the eighth time-base enable and stays open for a few clocks. The bench owns the enable input, so it knows the enable count modulo eight at every moment. It fires exactly eight enables, writes the seconds register on the next clock but one, and then shows through later reads that the time did not change. Seconds alarms need a full second of ticks. To keep that short, the bench runs the accumulator with a small, non-power-of-ten time-base rate.

// File: rtl/rtc_pkg.sv
// Package: register offsets and interrupt bit positions shared by the RTC.
// Assumes a byte-addressed 8-bit offset decoded in full.
package rtc_pkg;
    localparam logic [7:0] OFS_BUSY   = 8'h04;
    localparam logic [7:0] OFS_SEC    = 8'h08;
    localparam logic [7:0] OFS_SHADOW = 8'h0c;
    localparam logic [7:0] OFS_MSEC   = 8'h10;
    localparam logic [7:0] OFS_SALM0  = 8'h14;
    localparam logic [7:0] OFS_SALM1  = 8'h18;
    localparam logic [7:0] OFS_MALM   = 8'h1c;
    localparam logic [7:0] OFS_MASK   = 8'h28;
    localparam logic [7:0] OFS_STAT   = 8'h2c;

    localparam int NUM_EVT    = 5;
    localparam int EVT_SALM0  = 0;
    localparam int EVT_SALM1  = 1;
    localparam int EVT_MALM   = 2;
    localparam int EVT_SCDN   = 3;
    localparam int EVT_MCDN   = 4;
endpackage

// File: rtl/rtc_tick_gen.sv
// Tick generator: turns the time-base enable into average-exact millisecond
// ticks with a fractional accumulator, and opens a busy window of
// COPY_CYCLES clocks on every COPY_EVERY-th enable.
// Assumes COPY_CYCLES < COPY_EVERY and TICK_HZ <= TB_HZ.
module rtc_tick_gen #(
    parameter int TB_HZ       = 32768,
    parameter int TICK_HZ     = 1000,
    parameter int COPY_EVERY  = 8,
    parameter int COPY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tb_en,
    output logic ms_tick,
    output logic busy,
    output logic copy_load
);
    localparam int AW = $clog2(TB_HZ + TICK_HZ + 1);
    localparam int PW = (COPY_EVERY > 1) ? $clog2(COPY_EVERY) : 1;
    localparam int BW = $clog2(COPY_CYCLES + 1);

    logic [AW-1:0] acc_q;
    logic [AW-1:0] acc_sum;
    logic [PW-1:0] phase_q;
    logic [BW-1:0] busy_q;
    logic          copy_start;

    // Accumulator sum and tick decision for this enable.
    always_comb begin
        acc_sum    = acc_q + AW'(TICK_HZ);
        ms_tick    = tb_en && (acc_sum >= AW'(TB_HZ));
        copy_start = tb_en && (phase_q == PW'(COPY_EVERY - 1));
        busy       = (busy_q != '0);
        copy_load  = (busy_q == BW'(1));
    end

    // Fractional accumulator: keep the remainder after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_q <= '0;
        else if (ms_tick) acc_q <= acc_sum - AW'(TB_HZ);
        else if (tb_en)   acc_q <= acc_sum;
    end

    // Enable phase counter that paces the copy cadence.
    always_ff @(posedge clk) begin
        if (!rst_n)          phase_q <= '0;
        else if (copy_start) phase_q <= '0;
        else if (tb_en)      phase_q <= phase_q + PW'(1);
    end

    // Busy window countdown.
    always_ff @(posedge clk) begin
        if (!rst_n)          busy_q <= '0;
        else if (copy_start) busy_q <= BW'(COPY_CYCLES);
        else if (busy)       busy_q <= busy_q - BW'(1);
    end

    // R4: a copy start opens the busy window on the next cycle.
    p_busy_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
        copy_start |=> busy);
endmodule

// File: rtl/rtc_time_cnt.sv
// Time counter: live milliseconds and seconds. A seconds load clears
// milliseconds. Exposes next values and step strobes for alarm compares.
// Assumes ms_tick is at most one per clock.
module rtc_time_cnt #(
    parameter int MS_WRAP = 1000,
    parameter int SEC_W   = 32,
    localparam int MS_W   = $clog2(MS_WRAP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ms_tick,
    input  logic             sec_load,
    input  logic [SEC_W-1:0] sec_val,
    output logic [SEC_W-1:0] sec_q,
    output logic [MS_W-1:0]  ms_q,
    output logic [SEC_W-1:0] sec_nxt,
    output logic [MS_W-1:0]  ms_nxt,
    output logic             sec_step,
    output logic             ms_step
);
    logic wrap;

    // Next-value logic for a counting tick.
    always_comb begin
        wrap     = (ms_q == MS_W'(MS_WRAP - 1));
        ms_step  = ms_tick && !sec_load;
        sec_step = ms_step && wrap;
        ms_nxt   = wrap ? '0 : ms_q + MS_W'(1);
        sec_nxt  = sec_q + SEC_W'(1);
    end

    // Counter registers: load wins over counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_q <= '0;
            ms_q  <= '0;
        end else if (sec_load) begin
            sec_q <= sec_val;
            ms_q  <= '0;
        end else if (ms_step) begin
            ms_q <= ms_nxt;
            if (wrap) sec_q <= sec_nxt;
        end
    end

    // R3: milliseconds never reach the wrap value.
    p_ms_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ms_q < MS_W'(MS_WRAP));
    // R3: a wrap tick advances seconds by one.
    p_sec_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_tick && !sec_load && ms_q == MS_W'(MS_WRAP - 1))
        |=> (ms_q == '0 && sec_q == $past(sec_q) + SEC_W'(1)));
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Alarm and interrupt control: alarm registers, mask, sticky status with
// write-1-to-clear, and the level interrupt. Writes arrive already gated
// against busy. A zero alarm value never matches.
module rtc_irq_ctrl #(
    parameter int SEC_W  = 32,
    parameter int MS_W   = 10,
    parameter int NEVT   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_salm0,
    input  logic             wr_salm1,
    input  logic             wr_malm,
    input  logic             wr_mask,
    input  logic             wr_stat,
    input  logic [31:0]      wdata,
    input  logic             sec_step,
    input  logic             ms_step,
    input  logic [SEC_W-1:0] sec_nxt,
    input  logic [MS_W-1:0]  ms_nxt,
    output logic [SEC_W-1:0] salm0_q,
    output logic [SEC_W-1:0] salm1_q,
    output logic [MS_W-1:0]  malm_q,
    output logic [NEVT-1:0]  mask_q,
    output logic [NEVT-1:0]  stat_q,
    output logic             irq
);
    import rtc_pkg::*;

    logic [NEVT-1:0] hit;
    logic [NEVT-1:0] clr;

    // Alarm match events for this tick; countdown events are never raised.
    always_comb begin
        hit            = '0;
        hit[EVT_SALM0] = sec_step && (salm0_q != '0) && (sec_nxt == salm0_q);
        hit[EVT_SALM1] = sec_step && (salm1_q != '0) && (sec_nxt == salm1_q);
        hit[EVT_MALM]  = ms_step && (malm_q != '0) && (ms_nxt == malm_q);
        clr            = wr_stat ? wdata[NEVT-1:0] : '0;
        irq            = |(stat_q & mask_q);
    end

    // Alarm and mask registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            salm0_q <= '0;
            salm1_q <= '0;
            malm_q  <= '0;
            mask_q  <= '0;
        end else begin
            if (wr_salm0) salm0_q <= wdata[SEC_W-1:0];
            if (wr_salm1) salm1_q <= wdata[SEC_W-1:0];
            if (wr_malm)  malm_q  <= wdata[MS_W-1:0];
            if (wr_mask)  mask_q  <= wdata[NEVT-1:0];
        end
    end

    // Sticky status: a new event wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr) | hit;
    end

    // R11: a set bit not written with 1 stays set.
    p_w1c_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[EVT_SALM0] && !clr[EVT_SALM0]) |=> stat_q[EVT_SALM0]);
    // R13: countdown status bits are never raised.
    p_cdn_zero_r13: assert property (@(posedge clk) disable iff (!rst_n)
        stat_q[EVT_MCDN:EVT_SCDN] == 2'b00);
    // R10: a zero alarm cannot set its status bit.
    p_zero_alarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (salm0_q == '0 && !stat_q[EVT_SALM0] && !wr_salm0) |=> !stat_q[EVT_SALM0]);
endmodule

// File: rtl/rtc_shadowed.sv
// RTC top: register decode, busy-gated writes, bus-side time copy and
// shadow seconds captured by a milliseconds read. Read data is
// registered, one clock after rd_en.
module rtc_shadowed #(
    parameter int TB_HZ       = 32768,
    parameter int TICK_HZ     = 1000,
    parameter int MS_WRAP     = 1000,
    parameter int SEC_W       = 32,
    parameter int COPY_EVERY  = 8,
    parameter int COPY_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tb_en,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic        irq
);
    import rtc_pkg::*;

    localparam int MS_W = $clog2(MS_WRAP);

    logic             ms_tick, busy, copy_load;
    logic             wr_ok, wr_sec;
    logic [SEC_W-1:0] sec_q, sec_nxt, vis_sec, shadow_q;
    logic [MS_W-1:0]  ms_q, ms_nxt, vis_ms;
    logic             sec_step, ms_step;
    logic [SEC_W-1:0] salm0_q, salm1_q;
    logic [MS_W-1:0]  malm_q;
    logic [NUM_EVT-1:0] mask_q, stat_q;

    // Write gating: nothing is accepted inside the busy window.
    always_comb begin
        wr_ok  = wr_en && !busy;
        wr_sec = wr_ok && (addr == OFS_SEC);
    end

    rtc_tick_gen #(
        .TB_HZ(TB_HZ), .TICK_HZ(TICK_HZ),
        .COPY_EVERY(COPY_EVERY), .COPY_CYCLES(COPY_CYCLES)
    ) u_tick (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en),
        .ms_tick(ms_tick), .busy(busy), .copy_load(copy_load)
    );

    rtc_time_cnt #(.MS_WRAP(MS_WRAP), .SEC_W(SEC_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick),
        .sec_load(wr_sec), .sec_val(wdata[SEC_W-1:0]),
        .sec_q(sec_q), .ms_q(ms_q), .sec_nxt(sec_nxt), .ms_nxt(ms_nxt),
        .sec_step(sec_step), .ms_step(ms_step)
    );

    rtc_irq_ctrl #(.SEC_W(SEC_W), .MS_W(MS_W), .NEVT(NUM_EVT)) u_irq (
        .clk(clk), .rst_n(rst_n),
        .wr_salm0(wr_ok && addr == OFS_SALM0),
        .wr_salm1(wr_ok && addr == OFS_SALM1),
        .wr_malm (wr_ok && addr == OFS_MALM),
        .wr_mask (wr_ok && addr == OFS_MASK),
        .wr_stat (wr_ok && addr == OFS_STAT),
        .wdata(wdata), .sec_step(sec_step), .ms_step(ms_step),
        .sec_nxt(sec_nxt), .ms_nxt(ms_nxt),
        .salm0_q(salm0_q), .salm1_q(salm1_q), .malm_q(malm_q),
        .mask_q(mask_q), .stat_q(stat_q), .irq(irq)
    );

    // Bus-side copy: taken at the end of the busy window, or set by a seconds write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_sec <= '0;
            vis_ms  <= '0;
        end else if (wr_sec) begin
            vis_sec <= wdata[SEC_W-1:0];
            vis_ms  <= '0;
        end else if (copy_load) begin
            vis_sec <= sec_q;
            vis_ms  <= ms_q;
        end
    end

    // Shadow seconds captured by a milliseconds read.
    always_ff @(posedge clk) begin
        if (!rst_n)                            shadow_q <= '0;
        else if (rd_en && addr == OFS_MSEC)    shadow_q <= vis_sec;
    end

    // Registered read mux.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata <= '0;
        else if (rd_en) begin
            case (addr)
                OFS_BUSY:   rdata <= {31'b0, busy};
                OFS_SEC:    rdata <= 32'(vis_sec);
                OFS_SHADOW: rdata <= 32'(shadow_q);
                OFS_MSEC:   rdata <= 32'(vis_ms);
                OFS_SALM0:  rdata <= 32'(salm0_q);
                OFS_SALM1:  rdata <= 32'(salm1_q);
                OFS_MALM:   rdata <= 32'(malm_q);
                OFS_MASK:   rdata <= 32'(mask_q);
                OFS_STAT:   rdata <= 32'(stat_q);
                default:    rdata <= '0;
            endcase
        end
    end

    // R5: a seconds write inside the busy window leaves live time untouched.
    p_no_busy_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && busy && addr == OFS_SEC && !ms_tick) |=> $stable(sec_q));
    // R12: the interrupt never fires with an empty status.
    p_irq_needs_stat_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat_q != '0) && (mask_q != '0));
endmodule

// File: tb/sim_rtc_shadowed.sv
module sim_rtc_shadowed;
    localparam int TBHZ = 4096;
    localparam int THZ  = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tb_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    int total_en = 0;

    always #4 clk = ~clk;

    rtc_shadowed #(.TB_HZ(TBHZ), .TICK_HZ(THZ)) u0 (
        .clk(clk), .rst_n(rst_n), .tb_en(tb_en), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    // Enable increments; cumulative totals are all multiples of eight.
    localparam int NV = 6;
    localparam int STEP [NV] = '{8, 56, 128, 3904, 96, 4000};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        total_en = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); rd_en = 1'b1; addr = a;
        @(negedge clk); rd_en = 1'b0; v = rdata;
    endtask

    task automatic pulse(input int n);
        @(negedge clk); tb_en = 1'b1;
        repeat (n) @(negedge clk);
        tb_en = 1'b0;
        total_en += n;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        longint ms_tot;
        do_reset();

        // R1: reset state of every register
        begin
            logic [7:0] regs [9] = '{8'h04, 8'h08, 8'h0c, 8'h10, 8'h14, 8'h18, 8'h1c, 8'h28, 8'h2c};
            for (int i = 0; i < 9; i++) begin
                rd(regs[i], v);
                chk("R1 reset reg", v, 32'h0);
            end
        end
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R2/R3/R6: table walk of enable counts
        for (int i = 0; i < NV; i++) begin
            pulse(STEP[i]);
            repeat (8) @(negedge clk);
            ms_tot = (longint'(total_en) * THZ) / TBHZ;
            rd(8'h10, v);
            chk("R2 msec", v, 32'(ms_tot % 1000));
            rd(8'h0c, v);
            chk("R3 R6 shadow sec", v, 32'(ms_tot / 1000));
        end

        // R4/R5: write inside the busy window
        do_reset();
        pulse(8);
        rd(8'h04, v);
        chk("R4 busy high", v, 32'h1);
        do_reset();
        pulse(8);
        wr(8'h08, 32'd77);
        wr(8'h28, 32'h1f);
        repeat (8) @(negedge clk);
        rd(8'h04, v);
        chk("R4 busy low", v, 32'h0);
        rd(8'h08, v);
        chk("R5 sec unchanged", v, 32'h0);
        rd(8'h10, v);
        chk("R5 msec not cleared", v, 32'h1);
        rd(8'h28, v);
        chk("R5 mask unchanged", v, 32'h0);

        // R6/R7: shadow holds until the next milliseconds read
        do_reset();
        wr(8'h08, 32'd100);
        pulse(64);
        repeat (8) @(negedge clk);
        rd(8'h10, v);
        chk("R7 msec", v, 32'd15);
        wr(8'h08, 32'd200);
        rd(8'h0c, v);
        chk("R6 shadow held", v, 32'd100);
        rd(8'h08, v);
        chk("R7 sec set", v, 32'd200);
        rd(8'h10, v);
        chk("R7 msec cleared", v, 32'd0);
        rd(8'h0c, v);
        chk("R6 shadow new", v, 32'd200);

        // R10: all alarms zero across a seconds and a milliseconds wrap
        do_reset();
        pulse(4096);
        repeat (8) @(negedge clk);
        rd(8'h2c, v);
        chk("R10 no status", v, 32'h0);

        // R8/R11/R12: seconds alarms
        do_reset();
        wr(8'h08, 32'd5);
        wr(8'h14, 32'd6);
        wr(8'h18, 32'd6);
        pulse(4096);
        repeat (8) @(negedge clk);
        rd(8'h2c, v);
        chk("R8 alarm status", v, 32'h3);
        chk("R12 masked irq", {31'b0, irq}, 32'h0);
        wr(8'h28, 32'h2);
        chk("R12 irq on", {31'b0, irq}, 32'h1);
        wr(8'h2c, 32'h0);
        rd(8'h2c, v);
        chk("R11 zero write", v, 32'h3);
        wr(8'h2c, 32'h2);
        rd(8'h2c, v);
        chk("R11 clear one", v, 32'h1);
        chk("R12 irq off", {31'b0, irq}, 32'h0);
        wr(8'h2c, 32'hffff_ffff);
        rd(8'h2c, v);
        chk("R11 clear all", v, 32'h0);

        // R9: milliseconds alarm
        do_reset();
        wr(8'h1c, 32'd10);
        pulse(48);
        repeat (8) @(negedge clk);
        rd(8'h2c, v);
        chk("R9 msec alarm", v, 32'h4);

        // R13: mask width and countdown bits
        wr(8'h28, 32'hffff_ffff);
        rd(8'h28, v);
        chk("R13 mask width", v, 32'h1f);
        chk("R13 irq", {31'b0, irq}, 32'h1);
        rd(8'h2c, v);
        chk("R13 countdown zero", v & 32'h18, 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule